// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This unit collects the event pulses that a bus master's protocol engine raises and turns them into one interrupt request. Each pulse sets a sticky bit in a 16-bit status word. The enabled subset of those bits drives the interrupt line. Software clears handled bits by writing ones to them. A simple handler can also read a vector register instead. That register returns a small code for the most urgent enabled event and acknowledges the event in the same access.

Three registers sit on the register port: enable, status and vector. A two-bit selector chooses between them. Reads are combinational from the selected register. Writes and the acknowledge on a vector read take effect at the next rising clock edge. Bus busy is not stored. It is a live level that appears in the status word so that software can poll it before it starts a transfer.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, enable and status read as zero, the vector reads 0 and `irq` is low.
- R2: An event pulse sets its status bit at the next rising edge, and the bit stays set until it is cleared. The bit positions are: arbitration lost 0, no-acknowledge 1, access ready 2, receive ready 3, transmit ready 4, address zero 8, addressed as slave 9, transmit underflow 10, receive overrun 11, receive draining 13, transmit draining 14.
- R3: A write to the status register (selector 1) clears every stored bit that is written as one and leaves every bit written as zero unchanged.
- R4: Status bit 12 always equals the `busBusy` input in the same cycle. A write cannot clear it, and it never contributes to `irq`.
- R5: A write to the enable register (selector 0) stores only bits 0 to 4, 13 and 14. All other enable bits read as zero.
- R6: `irq` is high exactly when the stored status AND the enable register is nonzero.
- R7: A read of the vector register (selector 2) returns n+1, where n is the lowest of bits 0 to 4 that is both pending and enabled. It returns 0 if there is no such bit. Bits 13 and 14 are never vectored.
- R8: A vector read with a nonzero code clears only the status bit of that code, at the next edge.
- R9: If an event pulse coincides with a clear of the same bit, either by a status write or by a vector read, the bit stays set.
- R10: Writing zero to the enable register drops `irq` and leaves every pending status bit intact.
- R11: Selector 3 reads as zero. A read of the enable or status register changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regSel | input | 2 | Register select: 0 enable, 1 status, 2 vector, 3 none |
| regWr | input | 1 | Write strobe for the selected register |
| regRd | input | 1 | Read strobe; it takes effect only on the vector register |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data of the selected register |
| evArbLost | input | 1 | Event pulse: arbitration lost |
| evNoAck | input | 1 | Event pulse: no acknowledge |
| evAccessRdy | input | 1 | Event pulse: access ready |
| evRxRdy | input | 1 | Event pulse: receive data ready |
| evTxRdy | input | 1 | Event pulse: transmit data ready |
| evAddrZero | input | 1 | Event pulse: general-call address seen |
| evAsSlave | input | 1 | Event pulse: addressed as slave |
| evTxUnder | input | 1 | Event pulse: transmit underflow |
| evRxOver | input | 1 | Event pulse: receive overrun |
| evRxDrain | input | 1 | Event pulse: receive draining |
| evTxDrain | input | 1 | Event pulse: transmit draining |
| busBusy | input | 1 | Live bus busy level |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets these failure modes:
- Same-cycle collisions between a pulse and a write-one-to-clear or a vector acknowledge. A design that gives the clear priority would silently lose an event.
- Vector priority with several events pending, some of them masked. A wrong encoder would return a disabled code or a higher-numbered code.
- Over-clearing on a vector read. The design would then wipe neighbouring pending bits.
- Attempts to write bus busy and the non-maskable bits. These would leak into the enable register or into `irq`.
- A mask-then-unmask sequence. A design that clears status on masking would then fail to raise `irq` again when the mask is lifted.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int DATA_W   = 16;
  localparam int SEL_W    = 2;
  localparam int NUM_VEC  = 5;
  localparam int VEC_W    = $clog2(NUM_VEC + 1);

  localparam int BIT_BUSY = 12;

  localparam logic [DATA_W-1:0] ENABLE_MASK = 16'h601F;
  localparam logic [DATA_W-1:0] STORE_MASK  = 16'h6F1F;

  localparam logic [SEL_W-1:0] SEL_ENABLE = 2'd0;
  localparam logic [SEL_W-1:0] SEL_STATUS = 2'd1;
  localparam logic [SEL_W-1:0] SEL_VECTOR = 2'd2;

  typedef struct packed {
    logic              wrEnable;
    logic              wrStatus;
    logic              rdVector;
    logic [SEL_W-1:0]  rdSel;
    logic [DATA_W-1:0] wdata;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
(
  input  logic [SEL_W-1:0]  regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output ctrlStrobes_t      strobes
);
  always_comb begin
    strobes.wrEnable = regWr && (regSel == SEL_ENABLE);
    strobes.wrStatus = regWr && (regSel == SEL_STATUS);
    strobes.rdVector = regRd && (regSel == SEL_VECTOR);
    strobes.rdSel    = regSel;
    strobes.wdata    = regWdata;
  end
endmodule

// File: rtl/irq_status_datapath.sv
module irq_status_datapath
  import irq_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] eventVec,
  input  logic              busBusy,
  output logic [DATA_W-1:0] statusQ,
  output logic [DATA_W-1:0] enableQ,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [DATA_W-1:0] pending;
  logic [VEC_W-1:0]  vecCode;
  logic [DATA_W-1:0] vecOneHot;
  logic [DATA_W-1:0] clrMask;
  logic [DATA_W-1:0] statusNext;

  assign pending = statusQ & enableQ;

  // lowest-numbered pending event wins: scan downward so the last hit is the lowest
  always_comb begin
    vecCode   = '0;
    vecOneHot = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (pending[i]) begin
        vecCode   = VEC_W'(i + 1);
        vecOneHot = DATA_W'(1) << i;
      end
    end
  end

  always_comb begin
    clrMask = '0;
    if (strobes.wrStatus) clrMask = clrMask | strobes.wdata;
    if (strobes.rdVector) clrMask = clrMask | vecOneHot;
    // set has priority over clear
    statusNext = ((statusQ & ~clrMask) | eventVec) & STORE_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
    end else begin
      statusQ <= statusNext;
      if (strobes.wrEnable) enableQ <= strobes.wdata & ENABLE_MASK;
    end
  end

  always_comb begin
    unique case (strobes.rdSel)
      SEL_ENABLE: rdata = enableQ;
      SEL_STATUS: rdata = statusQ | (DATA_W'(busBusy) << BIT_BUSY);
      SEL_VECTOR: rdata = DATA_W'(vecCode);
      default:    rdata = '0;
    endcase
  end

  assign irq = |pending;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              evArbLost,
  input  logic              evNoAck,
  input  logic              evAccessRdy,
  input  logic              evRxRdy,
  input  logic              evTxRdy,
  input  logic              evAddrZero,
  input  logic              evAsSlave,
  input  logic              evTxUnder,
  input  logic              evRxOver,
  input  logic              evRxDrain,
  input  logic              evTxDrain,
  input  logic              busBusy,
  output logic              irq
);
  ctrlStrobes_t      strobes;
  logic [DATA_W-1:0] eventVec;
  logic [DATA_W-1:0] statusQ;
  logic [DATA_W-1:0] enableQ;

  always_comb begin
    eventVec     = '0;
    eventVec[0]  = evArbLost;
    eventVec[1]  = evNoAck;
    eventVec[2]  = evAccessRdy;
    eventVec[3]  = evRxRdy;
    eventVec[4]  = evTxRdy;
    eventVec[8]  = evAddrZero;
    eventVec[9]  = evAsSlave;
    eventVec[10] = evTxUnder;
    eventVec[11] = evRxOver;
    eventVec[13] = evRxDrain;
    eventVec[14] = evTxDrain;
  end

  irq_status_ctrl u_ctrl (
    .regSel   (regSel),
    .regWr    (regWr),
    .regRd    (regRd),
    .regWdata (regWdata),
    .strobes  (strobes)
  );

  irq_status_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .eventVec (eventVec),
    .busBusy  (busBusy),
    .statusQ  (statusQ),
    .enableQ  (enableQ),
    .rdata    (regRdata),
    .irq      (irq)
  );
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_status_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [SEL_W-1:0]  regSel,
  input logic              regWr,
  input logic              regRd,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic              evArbLost,
  input logic              evNoAck,
  input logic              busBusy,
  input logic [DATA_W-1:0] statusQ,
  input logic [DATA_W-1:0] enableQ,
  input logic              irq
);
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    evArbLost |=> statusQ[0]);

  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regSel == SEL_STATUS && regWdata[1] && !evNoAck) |=> !statusQ[1]);

  a_r4_busy_live: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == SEL_STATUS) |-> (regRdata[BIT_BUSY] == busBusy));

  a_r5_enable_bits: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ & ~ENABLE_MASK) == '0);

  a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (enableQ != '0));

  a_r8_vector_ack: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regSel == SEL_VECTOR && regRdata[VEC_W-1:0] == VEC_W'(1) && !evArbLost)
      |=> !statusQ[0]);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regSel == SEL_STATUS && regWdata[1] && evNoAck) |=> statusQ[1]);

  a_r10_mask_drops_irq: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regSel == SEL_ENABLE && regWdata == '0) |=> !irq);
endmodule

bind irq_status_unit irq_status_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regSel    (regSel),
  .regWr     (regWr),
  .regRd     (regRd),
  .regWdata  (regWdata),
  .regRdata  (regRdata),
  .evArbLost (evArbLost),
  .evNoAck   (evNoAck),
  .busBusy   (busBusy),
  .statusQ   (statusQ),
  .enableQ   (enableQ),
  .irq       (irq)
);

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [15:0] regWdata = 16'h0;
  logic [15:0] regRdata;
  logic [15:0] ev = 16'h0;
  logic        busBusy = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;
  int mStat = 0;
  int mEn = 0;

  always #10 clk = ~clk;

  irq_status_unit u_dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata),
    .evArbLost(ev[0]), .evNoAck(ev[1]), .evAccessRdy(ev[2]), .evRxRdy(ev[3]),
    .evTxRdy(ev[4]), .evAddrZero(ev[8]), .evAsSlave(ev[9]), .evTxUnder(ev[10]),
    .evRxOver(ev[11]), .evRxDrain(ev[13]), .evTxDrain(ev[14]),
    .busBusy(busBusy), .irq(irq)
  );

  function automatic int modelVec();
    int p = mStat & mEn;
    for (int i = 0; i < 5; i++) if ((p >> i) & 1) return i + 1;
    return 0;
  endfunction

  function automatic int modelRead(input int sel, input bit busy);
    case (sel)
      0: return mEn;
      1: return mStat | (busy ? 32'h1000 : 0);
      2: return modelVec();
      default: return 0;
    endcase
  endfunction

  task automatic step(input logic [15:0] e, input bit b, input logic [1:0] s,
                      input bit w, input bit r, input logic [15:0] d, input string req);
    int expRd;
    bit expIrq;
    int clr;
    int v;
    @(negedge clk);
    ev = e & 16'h6F1F; busBusy = b; regSel = s; regWr = w; regRd = r; regWdata = d;
    #1;
    expRd = modelRead(int'(s), b);
    expIrq = ((mStat & mEn) != 0);
    total++;
    if (int'(regRdata) != expRd) begin
      bad++;
      $display("FAIL %s regRdata sel=%0d actual=%h expected=%h", req, s, regRdata, expRd[15:0]);
    end
    total++;
    if (irq != expIrq) begin
      bad++;
      $display("FAIL %s irq actual=%0b expected=%0b", req, irq, expIrq);
    end
    @(posedge clk);
    v = modelVec();
    clr = 0;
    if (w && s == 2'd1) clr = int'(d);
    if (r && s == 2'd2 && v != 0) clr = clr | (1 << (v - 1));
    mStat = ((mStat & ~clr) | int'(e & 16'h6F1F)) & 32'h6F1F;
    if (w && s == 2'd0) mEn = int'(d) & 32'h601F;
  endtask

  task automatic idle(input logic [1:0] s, input string req);
    step(16'h0, 1'b0, s, 1'b0, 1'b0, 16'h0, req);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1 reset state on every selector
    idle(2'd0, "R1"); idle(2'd1, "R1"); idle(2'd2, "R1"); idle(2'd3, "R1");
    // R2 each event position, one at a time
    for (int i = 0; i < 15; i++) begin
      step(16'(1 << i), 1'b0, 2'd1, 1'b0, 1'b0, 16'h0, "R2");
      idle(2'd1, "R2");
    end
    // R3 partial clear
    step(16'h0, 1'b0, 2'd1, 1'b1, 1'b0, 16'h0A05, "R3");
    idle(2'd1, "R3");
    step(16'h0, 1'b0, 2'd1, 1'b1, 1'b0, 16'hFFFF, "R3");
    idle(2'd1, "R3");
    // R4 busy live and unclearable
    step(16'h0, 1'b1, 2'd1, 1'b1, 1'b0, 16'h1000, "R4");
    step(16'h0, 1'b1, 2'd1, 1'b0, 1'b0, 16'h0, "R4");
    step(16'h0, 1'b0, 2'd1, 1'b0, 1'b0, 16'h0, "R4");
    // R5 enable write mask
    step(16'h0, 1'b0, 2'd0, 1'b1, 1'b0, 16'hFFFF, "R5");
    idle(2'd0, "R5");
    step(16'h1000, 1'b1, 2'd0, 1'b0, 1'b0, 16'h0, "R4");
    idle(2'd1, "R4");
    step(16'h0F00, 1'b0, 2'd1, 1'b1, 1'b0, 16'hFFFF, "R6");
    // R6/R7 vector priority with masking
    step(16'h0, 1'b0, 2'd0, 1'b1, 1'b0, 16'h0016, "R7");
    step(16'h601F, 1'b0, 2'd2, 1'b0, 1'b0, 16'h0, "R7");
    idle(2'd2, "R7");
    // R8 vector reads acknowledge one at a time
    for (int k = 0; k < 4; k++) begin
      step(16'h0, 1'b0, 2'd2, 1'b0, 1'b1, 16'h0, "R8");
      idle(2'd1, "R8");
    end
    // R11 reads of enable and status do nothing
    step(16'h0, 1'b0, 2'd1, 1'b0, 1'b1, 16'h0, "R11");
    step(16'h0, 1'b0, 2'd0, 1'b0, 1'b1, 16'h0, "R11");
    step(16'h0, 1'b0, 2'd3, 1'b0, 1'b1, 16'h0, "R11");
    idle(2'd1, "R11");
    // R9 collisions
    step(16'h0, 1'b0, 2'd0, 1'b1, 1'b0, 16'h001F, "R9");
    step(16'h0002, 1'b0, 2'd1, 1'b1, 1'b0, 16'h6F1F, "R9");
    idle(2'd1, "R9");
    step(16'h0002, 1'b0, 2'd2, 1'b0, 1'b1, 16'h0, "R9");
    idle(2'd1, "R9");
    // R10 mask keeps status, unmask restores irq
    step(16'h0, 1'b0, 2'd0, 1'b1, 1'b0, 16'h0, "R10");
    idle(2'd1, "R10");
    step(16'h0, 1'b0, 2'd0, 1'b1, 1'b0, 16'h0002, "R10");
    idle(2'd2, "R10");
    // R6 mixed traffic
    for (int n = 0; n < 400; n++) begin
      step(16'($urandom & $urandom), 1'($urandom), 2'($urandom),
           ($urandom % 4) == 0, 1'($urandom), 16'($urandom), "R6");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule